// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller of a 12-bit successive-approximation converter. Every conversion takes a fixed number of clock periods. The first periods track the input. The remaining periods each resolve one result bit, from the most significant down to the least, using a single-bit comparator decision. When the last bit is resolved, the finished word moves into an output register. That register holds the word through the whole next conversion, and a data-ready flag marks the new word.

Conversions either run back to back or are started on demand. The start input is active low. While it is held low the sequencer runs freely. If start is high when the first tracking period ends, the sequencer parks in tracking period 2 and drops its clock-enable output, so the conversion clock can be stopped. A later low level on start resumes the count at the parked period. Two active-low enables gate the upper eight and lower four result bits onto the output bus, independently of each other. The data-ready flag is never gated.

The controller is a three-state machine:
- ST_TRACK covers periods 1 to 3.
- ST_PAUSE is the parked state in period 2.
- ST_TEST covers periods 4 to 15.

Its transitions are:
- T_ACQ_END: ST_TRACK to ST_TEST, taken at the end of period 3.
- T_PARK: ST_TRACK to ST_PAUSE, taken at the end of period 1 when start is high.
- T_RESUME: ST_PAUSE to ST_TRACK, taken when start is low.
- T_WRAP: ST_TEST to ST_TRACK, taken at the end of period 15.

All other edges stay in the same state and advance the period count.

Top module: `sar_seq_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves the block with the following values: period count 1, trial code 0, output register 0, data_rdy low and clk_en high.
- R2: While running, the period count advances by one on every rising edge, from 1 to 15. After 15 it wraps to 1.
- R3: track is high in periods 1 to 3 and while parked, and low in periods 4 to 15. Whenever track is high, the trial code is 0.
- R4: In period 4 the trial code has only bit 11 set (value 0x800).
- R5: In period p, for p from 5 to 15, the trial code is built as follows. Bit 15-p is set. Every higher bit holds the comparator decision taken at the end of its own period, where a high cmp_in keeps the bit and a low cmp_in clears it. Every lower bit is 0.
- R6: At the end of period 15, bit 0 takes the cmp_in value. The whole word then enters the output register and stays there unchanged until the end of the next period 15.
- R7: data_rdy rises on the edge into period 1 that loads the output register. It falls on the edge into period 2 when start_n is low at that edge.
- R8: start_n is sampled only at the end of period 1. Its level during periods 2 to 15 of a running conversion has no effect. Holding it low makes conversions run back to back.
- R9: If start_n is high at the end of period 1, the block parks in period 2. While parked, clk_en is low, track is high, the period count stays 2 and data_rdy keeps its value.
- R10: While parked, start_n low at an edge has these effects on that edge: clk_en goes high, data_rdy goes low and the period count stays 2. The following edges advance through 3, 4 and onwards.
- R11: When oe_hi_n is low, bits 11 to 4 of data_out show the output register and the matching data_oe bits are 1. When oe_lo_n is low, bits 3 to 0 do the same. A disabled bit reads 0 with data_oe 0. Each enable acts without a clock.
- R12: data_rdy does not depend on oe_hi_n or oe_lo_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Start request, active low |
| cmp_in | input | 1 | Comparator decision, high when the input is at or above the trial level |
| oe_hi_n | input | 1 | Active-low enable for result bits 11 to 4 |
| oe_lo_n | input | 1 | Active-low enable for result bits 3 to 0 |
| clk_en | output | 1 | Low while parked, so the conversion clock may be stopped |
| track | output | 1 | High while the input is tracked and the comparator auto-zeroes |
| data_rdy | output | 1 | New result available |
| period | output | 4 | Current period number, 1 to 15 |
| trial | output | 12 | Capacitor-switch trial code |
| data_out | output | 12 | Gated output register |
| data_oe | output | 12 | Per-bit output enable for data_out |

## Verification
The assertions check the structural rules on every cycle:
- the period count stays in range;
- the trial code is clear during tracking and equals the MSB-only pattern in the first hold period;
- data_rdy rises only in period 1;
- the output register changes only on entry to period 1;
- parking happens only in period 2 while tracking;
- parking is entered only from period 1.

Whether the resolved word equals the input value, and how start_n behaves around a park and a resume, can only be shown by the bench. It does this by comparing every output, on every cycle, against a behavioural model driven by a comparator that checks a stored input value against the trial code.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;
    typedef enum logic [1:0] {
        ST_TRACK = 2'd0,
        ST_PAUSE = 2'd1,
        ST_TEST  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/sar_period_fsm.sv
`timescale 1ns/1ps
module sar_period_fsm
    import sar_seq_pkg::*;
#(
    parameter int NBITS     = 12,
    parameter int TRACK_PER = 3,
    parameter int PW        = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_n,
    output logic [PW-1:0] period,
    output logic          track,
    output logic          clk_en,
    output logic          rdy,
    output logic          load_msb,
    output logic          test_en,
    output logic          last_tp
);
    localparam int NPER = TRACK_PER + NBITS;
    localparam logic [PW-1:0] P_ONE  = PW'(1);
    localparam logic [PW-1:0] P_PARK = PW'(2);
    localparam logic [PW-1:0] P_ACQ  = PW'(TRACK_PER);
    localparam logic [PW-1:0] P_LAST = PW'(NPER);

    seq_state_t    state_q, state_d;
    logic [PW-1:0] period_q, period_d;
    logic          rdy_q, rdy_d;

    // Next-state and next-period decision
    always_comb begin
        state_d  = state_q;
        period_d = period_q;
        rdy_d    = rdy_q;
        unique case (state_q)
            ST_TRACK: begin
                if (period_q == P_ONE && start_n) begin
                    // T_PARK
                    state_d  = ST_PAUSE;
                    period_d = P_PARK;
                end else begin
                    if (period_q == P_ONE) rdy_d = 1'b0;
                    if (period_q == P_ACQ) state_d = ST_TEST; // T_ACQ_END
                    period_d = period_q + P_ONE;
                end
            end
            ST_PAUSE: begin
                if (!start_n) begin
                    // T_RESUME
                    state_d = ST_TRACK;
                    rdy_d   = 1'b0;
                end
            end
            ST_TEST: begin
                if (period_q == P_LAST) begin
                    // T_WRAP
                    state_d  = ST_TRACK;
                    period_d = P_ONE;
                    rdy_d    = 1'b1;
                end else begin
                    period_d = period_q + P_ONE;
                end
            end
            default: begin
                state_d  = ST_TRACK;
                period_d = P_ONE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_TRACK;
            period_q <= P_ONE;
            rdy_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            period_q <= period_d;
            rdy_q    <= rdy_d;
        end
    end

    // Outputs
    always_comb begin
        period   = period_q;
        rdy      = rdy_q;
        track    = (state_q != ST_TEST);
        clk_en   = (state_q != ST_PAUSE);
        test_en  = (state_q == ST_TEST);
        load_msb = (state_q == ST_TRACK) && (period_q == P_ACQ);
        last_tp  = (state_q == ST_TEST) && (period_q == P_LAST);
    end
endmodule

// File: rtl/sar_trial_reg.sv
`timescale 1ns/1ps
module sar_trial_reg #(
    parameter int NBITS     = 12,
    parameter int TRACK_PER = 3,
    parameter int PW        = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_msb,
    input  logic             test_en,
    input  logic             last_tp,
    input  logic [PW-1:0]    period,
    input  logic             cmp_in,
    output logic [NBITS-1:0] trial,
    output logic [NBITS-1:0] result
);
    localparam int NPER = TRACK_PER + NBITS;
    localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

    logic [NBITS-1:0] trial_q, trial_d, result_q;
    int               bit_idx;

    // Decide the bit under test and arm the next one
    always_comb begin
        bit_idx = NPER - int'(period);
        trial_d = trial_q;
        for (int i = 0; i < NBITS; i++) begin
            if (i == bit_idx)
                trial_d[i] = cmp_in;
            else if (i == bit_idx - 1)
                trial_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trial_q  <= '0;
            result_q <= '0;
        end else if (load_msb) begin
            trial_q <= MSB_ONLY;
        end else if (last_tp) begin
            result_q <= trial_d;
            trial_q  <= '0;
        end else if (test_en) begin
            trial_q <= trial_d;
        end
    end

    assign trial  = trial_q;
    assign result = result_q;
endmodule

// File: rtl/sar_out_gate.sv
`timescale 1ns/1ps
module sar_out_gate #(
    parameter int NBITS   = 12,
    parameter int LO_BITS = 4
) (
    input  logic [NBITS-1:0] result,
    input  logic             oe_hi_n,
    input  logic             oe_lo_n,
    output logic [NBITS-1:0] data_out,
    output logic [NBITS-1:0] data_oe
);
    for (genvar g = 0; g < NBITS; g++) begin : g_bit
        if (g >= LO_BITS) begin : g_hi
            assign data_oe[g] = ~oe_hi_n;
        end else begin : g_lo
            assign data_oe[g] = ~oe_lo_n;
        end
        assign data_out[g] = result[g] & data_oe[g];
    end
endmodule

// File: rtl/sar_seq_ctrl.sv
`timescale 1ns/1ps
module sar_seq_ctrl #(
    parameter int NBITS     = 12,
    parameter int TRACK_PER = 3,
    parameter int LO_BITS   = 4,
    parameter int PW        = $clog2(TRACK_PER + NBITS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_n,
    input  logic             cmp_in,
    input  logic             oe_hi_n,
    input  logic             oe_lo_n,
    output logic             clk_en,
    output logic             track,
    output logic             data_rdy,
    output logic [PW-1:0]    period,
    output logic [NBITS-1:0] trial,
    output logic [NBITS-1:0] data_out,
    output logic [NBITS-1:0] data_oe
);
    logic             load_msb, test_en, last_tp;
    logic [NBITS-1:0] result_q;

    sar_period_fsm #(.NBITS(NBITS), .TRACK_PER(TRACK_PER), .PW(PW)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_n  (start_n),
        .period   (period),
        .track    (track),
        .clk_en   (clk_en),
        .rdy      (data_rdy),
        .load_msb (load_msb),
        .test_en  (test_en),
        .last_tp  (last_tp)
    );

    sar_trial_reg #(.NBITS(NBITS), .TRACK_PER(TRACK_PER), .PW(PW)) u_trial (
        .clk      (clk),
        .rst      (rst),
        .load_msb (load_msb),
        .test_en  (test_en),
        .last_tp  (last_tp),
        .period   (period),
        .cmp_in   (cmp_in),
        .trial    (trial),
        .result   (result_q)
    );

    sar_out_gate #(.NBITS(NBITS), .LO_BITS(LO_BITS)) u_gate (
        .result   (result_q),
        .oe_hi_n  (oe_hi_n),
        .oe_lo_n  (oe_lo_n),
        .data_out (data_out),
        .data_oe  (data_oe)
    );
endmodule

// File: rtl/sar_seq_chk.sv
`timescale 1ns/1ps
module sar_seq_chk #(
    parameter int NBITS     = 12,
    parameter int TRACK_PER = 3,
    parameter int PW        = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             clk_en,
    input logic             track,
    input logic             data_rdy,
    input logic [PW-1:0]    period,
    input logic [NBITS-1:0] trial,
    input logic [NBITS-1:0] result
);
    localparam int NPER = TRACK_PER + NBITS;
    localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

    assert_period_range_R2: assert property (@(posedge clk) disable iff (rst)
        (period >= PW'(1)) && (period <= PW'(NPER)));

    assert_trial_clear_R3: assert property (@(posedge clk) disable iff (rst)
        track |-> (trial == '0));

    assert_msb_first_R4: assert property (@(posedge clk) disable iff (rst)
        (!track && $past(track)) |-> (trial == MSB_ONLY));

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (period != PW'(1)) |-> $stable(result));

    assert_rdy_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(data_rdy) |-> (period == PW'(1)));

    assert_park_only_p1_R8: assert property (@(posedge clk) disable iff (rst)
        (clk_en && period != PW'(1)) |=> clk_en);

    assert_park_tracks_R9: assert property (@(posedge clk) disable iff (rst)
        !clk_en |-> (track && period == PW'(2)));
endmodule

bind sar_seq_ctrl sar_seq_chk #(.NBITS(NBITS), .TRACK_PER(TRACK_PER), .PW(PW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clk_en   (clk_en),
    .track    (track),
    .data_rdy (data_rdy),
    .period   (period),
    .trial    (trial),
    .result   (result_q)
);

// File: tb/tb_sar_seq_ctrl.sv
`timescale 1ns/1ps
module tb_sar_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_n = 1'b1;
    logic        oe_hi_n = 1'b0;
    logic        oe_lo_n = 1'b0;
    logic [11:0] vin = 12'd0;
    logic        cmp_in;
    logic        clk_en, track, data_rdy;
    logic [3:0]  period;
    logic [11:0] trial, data_out, data_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model state
    int          m_per = 1;
    bit          m_pause = 0;
    bit          m_rdy = 0;
    logic [11:0] m_trial = '0;
    logic [11:0] m_res = '0;

    always #10 clk = ~clk;

    // behavioural comparator on the trial code
    assign cmp_in = (vin >= trial);

    sar_seq_ctrl dut (
        .clk(clk), .rst(rst), .start_n(start_n), .cmp_in(cmp_in),
        .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n), .clk_en(clk_en),
        .track(track), .data_rdy(data_rdy), .period(period),
        .trial(trial), .data_out(data_out), .data_oe(data_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model, updated at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_per = 1; m_pause = 0; m_rdy = 0; m_trial = '0; m_res = '0;
        end else if (m_pause) begin
            if (!start_n) begin m_pause = 0; m_rdy = 0; end
        end else if (m_per <= 3) begin
            if (m_per == 1 && start_n) begin
                m_pause = 1; m_per = 2;
            end else begin
                if (m_per == 1) m_rdy = 0;
                if (m_per == 3) m_trial = 12'h800;
                m_per++;
            end
        end else begin
            int b;
            bit c;
            b = 15 - m_per;
            c = (vin >= m_trial);
            if (m_per == 15) begin
                m_res = {m_trial[11:1], c};
                m_trial = '0; m_per = 1; m_rdy = 1;
            end else begin
                m_trial[b] = c;
                m_trial[b-1] = 1'b1;
                m_per++;
            end
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        logic [11:0] e_oe;
        #8;
        e_oe = {{8{~oe_hi_n}}, {4{~oe_lo_n}}};
        chk(period == 4'(m_per), "R2 period", period, m_per);
        chk(track == (m_pause || m_per <= 3), "R3 track", track, (m_pause || m_per <= 3));
        chk(trial == m_trial, (m_per == 4) ? "R4 trial" : "R5 trial", trial, m_trial);
        chk(clk_en == !m_pause, "R9 clk_en", clk_en, !m_pause);
        chk(data_rdy == m_rdy, "R7 data_rdy", data_rdy, m_rdy);
        chk(data_oe == e_oe, "R11 data_oe", data_oe, e_oe);
        chk(data_out == (m_res & e_oe), "R6 data_out", data_out, m_res & e_oe);
    end

    task automatic after_edge();
        @(posedge clk); #8;
    endtask

    task automatic run_one(input logic [11:0] v);
        @(negedge clk); vin = v; start_n = 1'b0;
        after_edge();
        chk(clk_en && !data_rdy && period == 4'd2, "R10 resume", {clk_en, data_rdy, period}, 6'b100010);
        @(negedge clk); start_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(!clk_en && data_rdy, "R9 parked after conversion", {clk_en, data_rdy}, 2'b01);
        chk(data_out == v, "R6 result equals input", data_out, v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(period == 4'd1 && trial == 0 && data_out == 0 && !data_rdy && clk_en,
            "R1 reset", {period, trial}, 16'h1000);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(!clk_en && period == 4'd2 && track, "R9 park after reset", {clk_en, period}, 5'b00010);

        run_one(12'd0);
        run_one(12'hFFF);
        run_one(12'h800);
        run_one(12'h555);
        run_one(12'hAAA);
        run_one(12'h001);
        run_one(12'hABC);

        // R12: enables do not touch data_rdy while parked
        @(negedge clk); oe_hi_n = 1'b1;
        #1 chk(data_rdy == 1'b1 && data_out[11:4] == 0, "R12 oe_hi_n", data_rdy, 1);
        @(negedge clk); oe_lo_n = 1'b1; oe_hi_n = 1'b0;
        #1 chk(data_rdy == 1'b1 && data_oe == 12'hFF0, "R11 group split", data_oe, 12'hFF0);
        @(negedge clk); oe_lo_n = 1'b0;

        // R8: free-run, start_n pulsed high mid-conversion is ignored
        @(negedge clk); vin = 12'h3C7; start_n = 1'b0;
        repeat (6) @(negedge clk);
        start_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(clk_en == 1'b1, "R8 start ignored mid conversion", clk_en, 1);
        start_n = 1'b0;
        repeat (30) begin
            @(negedge clk);
            vin = vin + 12'h123;
            oe_hi_n = ~oe_hi_n;
        end
        oe_hi_n = 1'b0;
        repeat (2) begin
            @(negedge clk);
            while (period != 4'd15) @(negedge clk);
            vin = 12'h7E1;
            repeat (15) @(negedge clk);
        end
        chk(clk_en == 1'b1, "R8 free run continues", clk_en, 1);
        start_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(!clk_en, "R9 parks when start released", clk_en, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule